// File: doc/BRIEF.md
# Parallel Programming Target Port

This block is the device side of a byte-wide parallel programming port for a small microcontroller. A host presents a two-bit action code, a byte-select line and a data byte. On every rising edge of a load strobe it latches one of these: an address byte, a data byte or a command byte. An active-low write pulse then executes the loaded command. While output-enable is low, the block drives the read value of that command onto the data bus. A ready flag drops while a timed write is in progress.

Behind the port sit behavioural models of the targets. The program store is organised in 16-bit words. The data store is byte-wide. A pair of lock bits and a pair of fuse bits complete the set. Programming time is modelled by a parameterised busy counter. A chip erase is modelled as a sweep that writes all-ones into every location, one location per clock. The same sweep runs after reset, so both stores start erased.

The command, address and data registers keep their values between operations. A host therefore reloads only the bytes that change from one location to the next.

Top module: `pprog_port`

## Requirements
- R1: On a rising load strobe, the action code selects the target. 00 loads an address byte: the high byte when byte-select is 1, the low byte when it is 0. 01 loads a data byte, with the same byte-select rule. 10 loads the command register. 11 changes nothing.
- R2: With command 0x10, a falling write pulse stores a byte into the program word at {addr_hi,addr_lo} masked to PROG_AW bits. With byte-select 0 it stores the data low byte into bits 7:0 of the word. With byte-select 1 it stores the data high byte into bits 15:8.
- R3: An accepted program, data-store or lock write holds `rdy` low for exactly BUSY_CYCLES clocks. Strobes and write pulses that arrive while `rdy` is low are ignored.
- R4: With command 0x11, a write pulse stores the data low byte at the address masked to DATA_AW bits. With command 0x03, the read value is that byte.
- R5: With command 0x02, the read value is the low byte of the addressed program word when byte-select is 0 and the high byte when it is 1.
- R6: Command 0x80 followed by a write pulse sets every program word to 0xFFFF and every data byte to 0xFF. Reset starts the same sweep. The sweep takes max(2^PROG_AW, 2^DATA_AW) clocks, leaves `rdy` high, and ignores strobes and write pulses. At its end both lock bits return to 1. Fuse bits are unchanged.
- R7: Command 0x40 with a write pulse copies data low bit 5 into the serial-enable fuse and bit 0 into the start-up fuse, with no busy period.
- R8: Command 0x20 with a write pulse programs lock1 when data low bit 1 is 0 and lock2 when bit 2 is 0. A 1 never unprograms a lock bit; only the erase sweep does.
- R9: With command 0x04 and byte-select 1, the read value is {lock1, lock2, spi_fuse, 4'b1111, start_fuse}, where 0 means programmed. With byte-select 0 it is 0xFF.
- R10: While lock1 is programmed, program and data-store writes change no location and leave `rdy` high.
- R11: While both lock bits are programmed, program and data-store reads return 0xFF.
- R12: With command 0x08, address low byte 0, 1 and 2 select SIG0, SIG1 and SIG2. Any other value reads 0xFF.
- R13: Command, address and data bytes persist across operations until reloaded.
- R14: `dq_drive` equals the inverse of `oe_n`. An unknown command reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all port inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset; starts the erase sweep |
| strobe | input | 1 | Load strobe; acts on its rising edge |
| act | input | 2 | Action code for the load strobe |
| bsel | input | 1 | Byte select: 0 low, 1 high |
| wr_n | input | 1 | Active-low write pulse; acts on its falling edge |
| oe_n | input | 1 | Active-low output enable |
| dq_in | input | 8 | Data bus, inbound half |
| dq_out | output | 8 | Data bus, outbound half |
| dq_drive | output | 1 | High while the block drives the bus |
| rdy | output | 1 | 1 ready, 0 busy programming |

## Verification
Every word of a reduced program store and every byte of a reduced data store is written with arithmetic patterns. Low and high bytes carry different functions of the address, so a swapped byte half or a wrong word shows up as a mismatch.

Addresses carrying set bits above the mask width show whether the masking is right. A strobe or write issued during a busy period must leave the earlier address in effect.

The lock states are stepped through in order: unlocked, write-locked, fully locked, an attempted unlock with ones, then erase. This separates write blocking from read blanking and from lock stickiness. Fuse and lock values are chosen so that each field of the status byte differs from its neighbours.

// File: rtl/pprog_port.sv
module pprog_port #(
  parameter int PROG_AW = 12,
  parameter int DATA_AW = 9,
  parameter int BUSY_CYCLES = 16,
  parameter logic [7:0] SIG0 = 8'h1E,
  parameter logic [7:0] SIG1 = 8'h93,
  parameter logic [7:0] SIG2 = 8'h08
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe,
  input  logic [1:0] act,
  input  logic       bsel,
  input  logic       wr_n,
  input  logic       oe_n,
  input  logic [7:0] dq_in,
  output logic [7:0] dq_out,
  output logic       dq_drive,
  output logic       rdy
);
  localparam int PW = 1 << PROG_AW;
  localparam int DW = 1 << DATA_AW;
  localparam int SWEEP = (PW > DW) ? PW : DW;
  localparam int CW = $clog2(SWEEP + 1);
  localparam int BW = $clog2(BUSY_CYCLES + 1);

  logic [15:0] pmem [PW];
  logic [7:0]  dmem [DW];

  logic [7:0] cmd, adr_hi, adr_lo, dat_lo, dat_hi;
  logic lock1, lock2, fz_spi, fz_start;
  logic st_q, wr_q, erasing;
  logic [BW-1:0] bcnt;
  logic [CW-1:0] ecnt;

  wire [15:0]        adr     = {adr_hi, adr_lo};
  wire [PROG_AW-1:0] pa      = adr[PROG_AW-1:0];
  wire [DATA_AW-1:0] da      = adr[DATA_AW-1:0];
  wire               idle    = (bcnt == '0) && !erasing;
  wire               st_rise = strobe && !st_q && idle;
  wire               wr_fall = !wr_n && wr_q && idle;
  wire               wlock   = !lock1;
  wire               rlock   = !lock1 && !lock2;
  wire               do_pw   = wr_fall && cmd == 8'h10 && !wlock;
  wire               do_dw   = wr_fall && cmd == 8'h11 && !wlock;

  assign rdy      = (bcnt == '0);
  assign dq_drive = !oe_n;

  always_ff @(posedge clk) begin
    if (erasing) begin
      if (ecnt < CW'(PW)) pmem[ecnt[PROG_AW-1:0]] <= 16'hFFFF;
      if (ecnt < CW'(DW)) dmem[ecnt[DATA_AW-1:0]] <= 8'hFF;
    end else begin
      if (do_pw) begin
        if (bsel) pmem[pa][15:8] <= dat_hi;
        else      pmem[pa][7:0]  <= dat_lo;
      end
      if (do_dw) dmem[da] <= dat_lo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd <= '0; adr_hi <= '0; adr_lo <= '0; dat_lo <= '0; dat_hi <= '0;
      lock1 <= 1'b1; lock2 <= 1'b1; fz_spi <= 1'b1; fz_start <= 1'b1;
      st_q <= 1'b0; wr_q <= 1'b1; bcnt <= '0;
      erasing <= 1'b1; ecnt <= '0;
    end else begin
      st_q <= strobe;
      wr_q <= wr_n;
      if (bcnt != '0) bcnt <= bcnt - 1'b1;
      if (erasing) begin
        ecnt <= ecnt + 1'b1;
        if (ecnt == CW'(SWEEP - 1)) begin
          erasing <= 1'b0;
          lock1 <= 1'b1;
          lock2 <= 1'b1;
        end
      end
      if (st_rise) begin
        case (act)
          2'b00: if (bsel) adr_hi <= dq_in; else adr_lo <= dq_in;
          2'b01: if (bsel) dat_hi <= dq_in; else dat_lo <= dq_in;
          2'b10: cmd <= dq_in;
          default: ;
        endcase
      end
      if (wr_fall) begin
        case (cmd)
          8'h80: begin erasing <= 1'b1; ecnt <= '0; end
          8'h40: begin fz_spi <= dat_lo[5]; fz_start <= dat_lo[0]; end
          8'h20: begin
            lock1 <= lock1 & dat_lo[1];
            lock2 <= lock2 & dat_lo[2];
            bcnt  <= BW'(BUSY_CYCLES);
          end
          8'h10, 8'h11: if (!wlock) bcnt <= BW'(BUSY_CYCLES);
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    dq_out = 8'hFF;
    case (cmd)
      8'h02: if (!rlock) dq_out = bsel ? pmem[pa][15:8] : pmem[pa][7:0];
      8'h03: if (!rlock) dq_out = dmem[da];
      8'h04: if (bsel) dq_out = {lock1, lock2, fz_spi, 4'b1111, fz_start};
      8'h08: begin
        case (adr_lo)
          8'd0: dq_out = SIG0;
          8'd1: dq_out = SIG1;
          8'd2: dq_out = SIG2;
          default: dq_out = 8'hFF;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pprog_port_chk.sv
module pprog_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       strobe,
  input logic [1:0] act,
  input logic       wr_n,
  input logic       oe_n,
  input logic       rdy,
  input logic [7:0] dq_out,
  input logic [7:0] cmd,
  input logic       lock1,
  input logic       lock2,
  input logic       erasing
);
  AST_CMD_ONLY_BY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd) |-> ($past(strobe) && $past(act) == 2'b10)); // R1
  AST_BUSY_FREEZES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy |=> $stable(cmd)); // R3
  AST_RDY_FALL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> !$past(wr_n)); // R3
  AST_SWEEP_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    erasing |-> rdy); // R6
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock1 && !erasing) |=> !lock1); // R8
  AST_WRITE_LOCK_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock1 && rdy && (cmd == 8'h10 || cmd == 8'h11)) |=> rdy); // R10
  AST_READ_LOCK_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock1 && !lock2 && !oe_n && (cmd == 8'h02 || cmd == 8'h03)) |-> dq_out == 8'hFF); // R11
endmodule

bind pprog_port pprog_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .strobe(strobe), .act(act), .wr_n(wr_n),
  .oe_n(oe_n), .rdy(rdy), .dq_out(dq_out), .cmd(cmd), .lock1(lock1),
  .lock2(lock2), .erasing(erasing)
);

// File: tb/sim_pprog_port.sv
module sim_pprog_port;
  localparam int PAW = 5, DAW = 4, BUSY = 3;
  localparam int NP = 1 << PAW, ND = 1 << DAW;

  logic clk = 0, rst_n = 0, strobe = 0, bsel = 0, wr_n = 1, oe_n = 1;
  logic [1:0] act = 2'b11;
  logic [7:0] dq_in = 0;
  logic [7:0] dq_out;
  logic dq_drive, rdy;
  int checks = 0, fails = 0;
  bit done = 0;

  pprog_port #(.PROG_AW(PAW), .DATA_AW(DAW), .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .act(act), .bsel(bsel),
    .wr_n(wr_n), .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out),
    .dq_drive(dq_drive), .rdy(rdy));

  always #2 clk = ~clk;

  function automatic logic [7:0] plo(int a); return 8'(a * 7 + 3); endfunction
  function automatic logic [7:0] phi(int a); return 8'(a) ^ 8'h5A; endfunction
  function automatic logic [7:0] dv(int a);  return 8'(a * 13 + 1); endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic ld(logic [1:0] a, logic b, logic [7:0] v);
    @(negedge clk); act = a; bsel = b; dq_in = v; strobe = 1;
    @(negedge clk); strobe = 0;
    @(negedge clk);
  endtask

  task automatic wpulse(logic b, output int lowcnt);
    @(negedge clk); bsel = b; wr_n = 0;
    @(negedge clk); wr_n = 1;
    lowcnt = 0;
    while (!rdy && lowcnt < 100) begin lowcnt++; @(negedge clk); end
  endtask

  task automatic rd(logic b, output logic [7:0] v);
    @(negedge clk); bsel = b; oe_n = 0;
    #1 v = dq_out;
    @(negedge clk); oe_n = 1;
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    logic [7:0] v;
    waitn(3);
    chk("R3 reset rdy", {7'd0, rdy}, 8'd1);
    chk("R14 reset drive", {7'd0, dq_drive}, 8'd0);
    rst_n = 1;
    waitn(NP + 4);

    ld(2'b10, 0, 8'h02); ld(2'b00, 1, 8'h00); ld(2'b00, 0, 8'h04);
    rd(0, v); chk("R6 reset erase low", v, 8'hFF);
    rd(1, v); chk("R6 reset erase high", v, 8'hFF);
    @(negedge clk); oe_n = 0; #1 chk("R14 drive on", {7'd0, dq_drive}, 8'd1);
    @(negedge clk); oe_n = 1; #1 chk("R14 drive off", {7'd0, dq_drive}, 8'd0);

    // R2 R3: full program sweep
    ld(2'b10, 0, 8'h10);
    for (int a = 0; a < NP; a++) begin
      ld(2'b00, 0, 8'(a));
      ld(2'b01, 0, plo(a)); wpulse(0, n); chk("R3 busy len", 8'(n), 8'(BUSY));
      ld(2'b01, 1, phi(a)); wpulse(1, n); chk("R3 busy len", 8'(n), 8'(BUSY));
    end
    ld(2'b10, 0, 8'h02);
    for (int a = 0; a < NP; a++) begin
      ld(2'b00, 0, 8'(a));
      rd(0, v); chk("R5 R2 low byte", v, plo(a));
      rd(1, v); chk("R5 R2 high byte", v, phi(a));
    end
    rd(0, v); chk("R13 address persists", v, plo(NP - 1));
    ld(2'b11, 0, 8'h03);
    rd(0, v); chk("R1 idle action", v, plo(NP - 1));

    // R2 masking: address 0x12_25 lands in word 5
    ld(2'b10, 0, 8'h10); ld(2'b00, 1, 8'h12); ld(2'b00, 0, 8'h25);
    ld(2'b01, 0, 8'hC3); wpulse(0, n);
    ld(2'b10, 0, 8'h02); ld(2'b00, 1, 8'h00); ld(2'b00, 0, 8'h05);
    rd(0, v); chk("R2 mask", v, 8'hC3);
    rd(1, v); chk("R2 mask other half", v, phi(5));

    // R4 data store sweep
    ld(2'b10, 0, 8'h11);
    for (int a = 0; a < ND; a++) begin
      ld(2'b00, 0, 8'(a)); ld(2'b01, 0, dv(a));
      wpulse(0, n); chk("R4 R3 busy len", 8'(n), 8'(BUSY));
    end
    ld(2'b10, 0, 8'h03);
    for (int a = 0; a < ND; a++) begin
      ld(2'b00, 0, 8'(a)); rd(0, v); chk("R4 data read", v, dv(a));
    end
    ld(2'b10, 0, 8'h11); ld(2'b00, 1, 8'h01); ld(2'b00, 0, 8'h1A);
    ld(2'b01, 0, 8'h77); wpulse(0, n);
    ld(2'b10, 0, 8'h03); ld(2'b00, 1, 8'h00); ld(2'b00, 0, 8'h0A);
    rd(0, v); chk("R4 mask", v, 8'h77);

    // R3 strobe during busy is ignored
    ld(2'b10, 0, 8'h10); ld(2'b00, 0, 8'h07); ld(2'b01, 0, 8'h3C);
    @(negedge clk); bsel = 0; wr_n = 0;
    @(negedge clk); wr_n = 1;
    @(negedge clk); act = 2'b00; bsel = 0; dq_in = 8'h09; strobe = 1;
    @(negedge clk); strobe = 0;
    waitn(6);
    ld(2'b10, 0, 8'h02);
    rd(0, v); chk("R3 busy strobe ignored", v, 8'h3C);

    // R12 signature
    ld(2'b10, 0, 8'h08);
    for (int a = 0; a < 4; a++) begin
      ld(2'b00, 0, 8'(a)); rd(0, v);
      chk("R12 signature", v, a == 0 ? 8'h1E : a == 1 ? 8'h93 : a == 2 ? 8'h08 : 8'hFF);
    end
    ld(2'b10, 0, 8'h55); rd(0, v); chk("R14 unknown cmd", v, 8'hFF);

    // R7 fuses, R9 status layout
    ld(2'b10, 0, 8'h40); ld(2'b01, 0, 8'hDE); wpulse(0, n);
    chk("R7 fuse no busy", 8'(n), 8'd0);
    ld(2'b10, 0, 8'h04);
    rd(1, v); chk("R9 R7 status", v, 8'hDE);
    rd(0, v); chk("R9 bsel0", v, 8'hFF);

    // R8 R10 write lock
    ld(2'b10, 0, 8'h20); ld(2'b01, 0, 8'hFD); wpulse(0, n);
    chk("R8 lock busy", 8'(n), 8'(BUSY));
    ld(2'b10, 0, 8'h04); rd(1, v); chk("R8 lock1", v, 8'h5E);
    ld(2'b10, 0, 8'h10); ld(2'b00, 0, 8'h03); ld(2'b01, 0, 8'h00);
    wpulse(0, n); chk("R10 no busy", 8'(n), 8'd0);
    ld(2'b10, 0, 8'h11); wpulse(0, n); chk("R10 data no busy", 8'(n), 8'd0);
    ld(2'b10, 0, 8'h02); rd(0, v); chk("R10 program kept", v, plo(3));
    ld(2'b10, 0, 8'h03); rd(0, v); chk("R10 data kept", v, dv(3));

    // R11 full lock, R8 stickiness
    ld(2'b10, 0, 8'h20); ld(2'b01, 0, 8'hFB); wpulse(0, n);
    ld(2'b10, 0, 8'h04); rd(1, v); chk("R8 both locks", v, 8'h1E);
    ld(2'b10, 0, 8'h02); rd(0, v); chk("R11 program blank", v, 8'hFF);
    ld(2'b10, 0, 8'h03); rd(0, v); chk("R11 data blank", v, 8'hFF);
    ld(2'b10, 0, 8'h20); ld(2'b01, 0, 8'hFF); wpulse(0, n);
    ld(2'b10, 0, 8'h04); rd(1, v); chk("R8 no unlock", v, 8'h1E);
    ld(2'b10, 0, 8'h08); ld(2'b00, 0, 8'h01); rd(0, v); chk("R12 sig while locked", v, 8'h93);

    // R6 chip erase
    ld(2'b10, 0, 8'h80); wpulse(0, n); chk("R6 erase no busy", 8'(n), 8'd0);
    ld(2'b10, 0, 8'h04);
    waitn(NP + 4);
    rd(1, v); chk("R6 strobe ignored in sweep", v, 8'hFF);
    ld(2'b10, 0, 8'h04); rd(1, v); chk("R6 locks back fuses kept", v, 8'hDE);
    ld(2'b10, 0, 8'h02);
    for (int a = 0; a < NP; a += 7) begin
      ld(2'b00, 0, 8'(a)); rd(0, v); chk("R6 program erased", v, 8'hFF);
      rd(1, v); chk("R6 program erased high", v, 8'hFF);
    end
    ld(2'b10, 0, 8'h03); rd(0, v); chk("R6 data erased", v, 8'hFF);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule